// File: doc/BRIEF.md
# Multistage Barrel Shifter with Shift Modes

This block shifts a 32-bit operand by any amount from 0 to 31 in a single combinational pass. The shift is performed by a chain of five multiplexer stages that move the data by 16, 8, 4, 2 and 1 positions. Each stage either passes its input unchanged or applies its own fixed shift. Because the stages are chained, the distances of the enabled stages add up to the requested amount.

A 2-bit mode code selects the kind of shift: none, logical left, logical right or arithmetic right. The logical shifts fill the vacated positions with zeros. The arithmetic right shift fills the vacated high positions with copies of the operand's sign bit. A small control module turns the amount and the mode into one select strobe per stage. The datapath module applies those strobes. The block has no clock and no state, so the result follows the inputs within the same cycle. It is intended to sit in the execute stage of an integer datapath.

Top module: `barrel_shift_unit`

## Requirements
- R1: With mode code 2'b00 (no shift), dataOut equals dataIn for every shiftAmt.
- R2: With mode code 2'b01 (logical left), dataOut equals dataIn shifted toward bit 31 by shiftAmt places, and the low shiftAmt bits are 0.
- R3: With mode code 2'b10 (logical right), dataOut equals dataIn shifted toward bit 0 by shiftAmt places, and the high shiftAmt bits are 0.
- R4: With mode code 2'b11 (arithmetic right), dataOut equals dataIn shifted toward bit 0 by shiftAmt places, and the high shiftAmt bits all equal dataIn[31].
- R5: With shiftAmt of 0, dataOut equals dataIn in all four modes.
- R6: At shiftAmt 31, the results are as follows. Logical left leaves only dataIn[0] at bit 31. Logical right leaves only dataIn[31] at bit 0. Arithmetic right gives all 32 bits equal to dataIn[31].
- R7: In arithmetic right mode, dataOut[31] always equals dataIn[31].
- R8: dataOut is a combinational function of the present inputs and depends on no earlier input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 32 | Operand to be shifted |
| shiftAmt | input | 5 | Shift distance, 0 to 31 |
| shiftMode | input | 2 | 00 none, 01 logical left, 10 logical right, 11 arithmetic right |
| dataOut | output | 32 | Shifted result |

## Verification
The bench checks negative operands in arithmetic mode. A shifter that filled from a stage's zero-filled output rather than from the sign would clear the high bits. One that used logical fill by mistake would also lose the sign.

Every amount from 0 to 31 is swept in each mode. A stage that is wired to the wrong amount bit, or that ignores its bit, gives wrong results for exactly the amounts that use that stage.

Two further cases are tested:
- Amount 31 with operands that have only their end bits set. This exposes off-by-one slicing at the word boundary.
- Nonzero amounts in no-shift mode. This catches a design that lets the amount leak through when no shift is requested.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [1:0] {
    SEL_PASS = 2'b00,
    SEL_LEFT = 2'b01,
    SEL_RLOG = 2'b10,
    SEL_RARI = 2'b11
  } stage_sel_e;

  typedef struct packed {
    stage_sel_e sel;
  } stage_strobe_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic [AMT_W-1:0]          shiftAmt,
  input  logic [1:0]                shiftMode,
  output stage_strobe_t [AMT_W-1:0] strobes
);

  stage_sel_e modeSel;
  assign modeSel = stage_sel_e'(shiftMode);

  for (genvar i = 0; i < AMT_W; i++) begin : g_strobe
    always_comb begin
      if (shiftAmt[i]) strobes[i].sel = modeSel;
      else             strobes[i].sel = SEL_PASS;
    end
  end

endmodule

// File: rtl/shift_stage.sv
module shift_stage
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 1
) (
  input  logic [DATA_W-1:0] dIn,
  input  stage_sel_e        sel,
  output logic [DATA_W-1:0] dOut
);

  logic signBit;
  assign signBit = dIn[DATA_W-1];

  always_comb begin
    unique case (sel)
      SEL_PASS: dOut = dIn;
      SEL_LEFT: dOut = {dIn[DATA_W-1-STEP:0], {STEP{1'b0}}};
      SEL_RLOG: dOut = {{STEP{1'b0}}, dIn[DATA_W-1:STEP]};
      SEL_RARI: dOut = {{STEP{signBit}}, dIn[DATA_W-1:STEP]};
      default:  dOut = dIn;
    endcase
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input  logic [DATA_W-1:0]         dataIn,
  input  stage_strobe_t [AMT_W-1:0] strobes,
  output logic [DATA_W-1:0]         dataOut
);

  logic [DATA_W-1:0] chain [AMT_W+1];

  assign chain[0] = dataIn;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int BIT_IDX = AMT_W - 1 - k;
    shift_stage #(
      .DATA_W(DATA_W),
      .STEP  (1 << BIT_IDX)
    ) u_stage (
      .dIn (chain[k]),
      .sel (strobes[BIT_IDX].sel),
      .dOut(chain[k+1])
    );
  end

  assign dataOut = chain[AMT_W];

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [1:0]        shiftMode,
  output logic [DATA_W-1:0] dataOut
);

  stage_strobe_t [AMT_W-1:0] strobes;

  shift_ctrl #(
    .AMT_W(AMT_W)
  ) u_ctrl (
    .shiftAmt (shiftAmt),
    .shiftMode(shiftMode),
    .strobes  (strobes)
  );

  shift_datapath #(
    .DATA_W(DATA_W),
    .AMT_W (AMT_W)
  ) u_dp (
    .dataIn (dataIn),
    .strobes(strobes),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/barrel_shift_checker.sv
module barrel_shift_checker #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input logic [DATA_W-1:0] dataIn,
  input logic [AMT_W-1:0]  shiftAmt,
  input logic [1:0]        shiftMode,
  input logic [DATA_W-1:0] dataOut
);

  always_comb begin
    if (!$isunknown({dataIn, shiftAmt, shiftMode})) begin
      a_r1_no_shift_passes: assert (shiftMode != 2'b00 || dataOut == dataIn)
        else $error("R1 pass mode altered data");
      a_r5_zero_amount_passes: assert (shiftAmt != '0 || dataOut == dataIn)
        else $error("R5 zero amount altered data");
      a_r7_arith_keeps_sign: assert (shiftMode != 2'b11 || dataOut[DATA_W-1] == dataIn[DATA_W-1])
        else $error("R7 arithmetic shift lost sign");
      a_r3_right_zero_top: assert (shiftMode != 2'b10 || shiftAmt == '0 || !dataOut[DATA_W-1])
        else $error("R3 logical right top bit not zero");
      a_r2_left_zero_bottom: assert (shiftMode != 2'b01 || shiftAmt == '0 || !dataOut[0])
        else $error("R2 logical left bottom bit not zero");
    end
  end

endmodule

bind barrel_shift_unit barrel_shift_checker #(
  .DATA_W(DATA_W),
  .AMT_W (AMT_W)
) u_checker (
  .dataIn   (dataIn),
  .shiftAmt (shiftAmt),
  .shiftMode(shiftMode),
  .dataOut  (dataOut)
);

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dataIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic [1:0]  shiftMode = '0;
  logic [31:0] dataOut;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  barrel_shift_unit u_barrel_shift_unit (
    .dataIn   (dataIn),
    .shiftAmt (shiftAmt),
    .shiftMode(shiftMode),
    .dataOut  (dataOut)
  );

  function automatic logic [31:0] model(logic [31:0] x, int amt, logic [1:0] m);
    logic [31:0] r;
    case (m)
      2'b00:   r = x;
      2'b01:   r = x << amt;
      2'b10:   r = x >> amt;
      default: r = $signed(x) >>> amt;
    endcase
    return r;
  endfunction

  task automatic apply(logic [31:0] x, int amt, logic [1:0] m);
    @(negedge clk);
    dataIn = x;
    shiftAmt = amt[4:0];
    shiftMode = m;
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    apply(32'h0, 0, 2'b00);
    check("R8 initial zero", dataOut, 32'h0);
  endtask

  task automatic t_no_shift();
    for (int a = 0; a < 32; a += 7) begin
      apply(32'hDEAD_BEEF, a, 2'b00);
      check("R1 no-shift mode", dataOut, 32'hDEAD_BEEF);
    end
  endtask

  task automatic t_zero_amount();
    for (int m = 0; m < 4; m++) begin
      apply(32'h8123_4567, 0, m[1:0]);
      check("R5 zero amount", dataOut, 32'h8123_4567);
    end
  endtask

  task automatic t_left();
    apply(32'h0000_00FF, 4, 2'b01);
    check("R2 left by 4", dataOut, 32'h0000_0FF0);
    apply(32'hFFFF_FFFF, 17, 2'b01);
    check("R2 left zero fill", dataOut, 32'hFFFE_0000);
  endtask

  task automatic t_right_log();
    apply(32'hF000_0000, 4, 2'b10);
    check("R3 right by 4", dataOut, 32'h0F00_0000);
    apply(32'hFFFF_FFFF, 9, 2'b10);
    check("R3 right zero fill", dataOut, 32'h007F_FFFF);
  endtask

  task automatic t_right_arith();
    apply(32'h8000_0000, 3, 2'b11);
    check("R4 arith negative", dataOut, 32'hF000_0000);
    apply(32'h7000_0000, 3, 2'b11);
    check("R4 arith positive", dataOut, 32'h0E00_0000);
    apply(32'hA5A5_0000, 21, 2'b11);
    check("R7 arith keeps sign", {31'h0, dataOut[31]}, 32'h1);
  endtask

  task automatic t_extremes();
    apply(32'h0000_0001, 31, 2'b01);
    check("R6 left 31", dataOut, 32'h8000_0000);
    apply(32'hFFFF_FFFE, 31, 2'b01);
    check("R6 left 31 clear", dataOut, 32'h0);
    apply(32'h8000_0000, 31, 2'b10);
    check("R6 right 31", dataOut, 32'h1);
    apply(32'h8000_0000, 31, 2'b11);
    check("R6 arith 31 neg", dataOut, 32'hFFFF_FFFF);
    apply(32'h7FFF_FFFF, 31, 2'b11);
    check("R6 arith 31 pos", dataOut, 32'h0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 32; a++) begin
        for (int n = 0; n < 3; n++) begin
          logic [31:0] x;
          x = $urandom();
          if (n == 0) x[31] = 1'b1;
          apply(x, a, m[1:0]);
          check("R2 R3 R4 sweep", dataOut, model(x, a, m[1:0]));
        end
      end
    end
  endtask

  task automatic t_no_memory();
    apply(32'hFFFF_FFFF, 31, 2'b11);
    apply(32'h0000_1234, 0, 2'b10);
    check("R8 no history", dataOut, 32'h0000_1234);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_no_shift();
    t_zero_amount();
    t_left();
    t_right_log();
    t_right_arith();
    t_extremes();
    t_sweep();
    t_no_memory();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule